// File: doc/BRIEF.md
# Multi-Format Synchronous Serial Master

This block is a synchronous serial master that turns 32-bit words taken from a transmit queue into serial frames on a clock, select, data-out and data-in pin set, and assembles the bits it samples into words that it places in a receive queue. A single shift engine handles three framing styles: a classic four-wire SPI frame with selectable clock polarity and phase, a TI-style frame announced by a one-bit-wide pulse, and a MicroWire exchange in which an 8-bit command goes out and a reply frame comes back.

Software or a DMA engine writes words through the push port and reads replies through the pop port. Level flags and two DMA request lines pace the traffic. A sticky flag records a frame lost because the receive queue was full. The frame length runs from 4 to 32 bits. The bit rate comes from a prescaler followed by a divider.

Top module: `mfsp_top`

## Requirements
- R1: With `cfg_fmt`=0 (SPI, and also code 3), `ser_sel` is low from the first to the last bit of a frame and high when idle. Bits leave MSB first, one per bit period, on `ser_mosi`, and `ser_mosi` is 0 when no bit is being sent.
- R2: `cfg_size` holds the frame length minus one, and codes below 3 act as 3. Only the low frame-length bits of a transmit word are sent. A received word carries the last frame-length sampled bits in its low bits, with zeros above them.
- R3: Each half bit period lasts (`cfg_pre`+1)*(`cfg_div`+1) clock cycles.
- R4: In SPI mode `ser_clk` idles at `cfg_cpol`. With `cfg_cpha`=0 data is sampled on the first clock edge of each bit. With `cfg_cpha`=1 it is sampled on the second.
- R5: With `cfg_fmt`=1 (TI), `ser_sel` is high for exactly one bit period just before the first data bit, with `ser_mosi` low during that period. The clock idles low and data is sampled on its falling edge.
- R6: With `cfg_fmt`=2 (MicroWire), bits [7:0] of the word are sent MSB first, then frame-length bits are received while `ser_mosi` stays low. `ser_sel` stays low for the whole exchange, and data is sampled on rising clock edges.
- R7: The transmit queue holds 32 words. `tx_full` and `tx_empty` report its state, and a push while it is full is dropped.
- R8: The receive queue holds 32 words. `rx_data` shows the oldest word, and `rx_pop` removes it.
- R9: `dma_tx_req` is high while the transmit queue holds 16 words or fewer. `dma_rx_req` is high while the receive queue is not empty.
- R10: A frame that completes while the receive queue is full is discarded and sets `rx_ovr`. The flag stays set until `ovr_clr` is pulsed, and a new overrun in the same cycle wins over the clear.
- R11: After reset both queues are empty, `rx_ovr` is 0 and the serial pins are at their idle levels.
- R12: While `cfg_en` is low no new frame starts, and words wait in the transmit queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Allow new frames to start |
| cfg_fmt | input | 2 | Framing: 0 SPI, 1 TI, 2 MicroWire |
| cfg_size | input | 5 | Frame length minus one |
| cfg_pre | input | 8 | Prescaler value |
| cfg_div | input | 8 | Divider value |
| cfg_cpol | input | 1 | SPI idle clock level |
| cfg_cpha | input | 1 | SPI sampling edge select |
| tx_push | input | 1 | Write a word to the transmit queue |
| tx_data | input | 32 | Word to write |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_pop | input | 1 | Remove the oldest received word |
| rx_data | output | 32 | Oldest received word |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| ovr_clr | input | 1 | Clear the overrun flag |
| rx_ovr | output | 1 | Sticky receive overrun |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| ser_clk | output | 1 | Serial clock |
| ser_sel | output | 1 | Select (SPI, MicroWire) or frame pulse (TI) |
| ser_mosi | output | 1 | Serial data out |
| ser_miso | input | 1 | Serial data in |

## Verification
A bench slave watches the sampling edge chosen by each framing style and plays a known reply stream. Distinct words in SPI with three polarity and phase pairs show whether bit order, edge choice and idle level are right. Frames of 32, 4 and clamped lengths, sent with words whose high bits are set, show whether masking and zero-extension are right. TI and MicroWire frames show whether the pulse width, the command-then-reply split and the held select are right. A run with the engine disabled fills and overfills the queues, then drains them into a full receive queue, and this separates a dropped push from a discarded frame.

// File: rtl/mfsp_pkg.sv
package mfsp_pkg;
    typedef enum logic [1:0] {
        FMT_SPI = 2'd0,
        FMT_TI  = 2'd1,
        FMT_MW  = 2'd2
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_BITS = 2'd2
    } st_e;

    localparam int CMD_BITS = 8;
    localparam int MIN_CODE = 3;
endpackage

// File: rtl/mfsp_fifo.sv
module mfsp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_s;

    fifo_s         st_d, st_q;
    logic [W-1:0]  mem [DEPTH];
    logic          do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        if (do_pop)  st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr] <= din;
    end

    assign dout  = mem[st_q.rd];
    assign count = st_q.cnt;
endmodule

// File: rtl/mfsp_clkgen.sv
module mfsp_clkgen #(
    parameter int PW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] pre,
    input  logic [DW-1:0] div,
    output logic          tick
);
    typedef struct packed {
        logic [PW-1:0] pcnt;
        logic [DW-1:0] dcnt;
    } cg_s;

    cg_s  cg_d, cg_q;
    logic pre_end, div_end;

    assign pre_end = (cg_q.pcnt == pre);
    assign div_end = (cg_q.dcnt == div);
    assign tick    = run && pre_end && div_end;

    always_comb begin
        cg_d = cg_q;
        if (!run) begin
            cg_d = '0;
        end else if (pre_end) begin
            cg_d.pcnt = '0;
            cg_d.dcnt = div_end ? '0 : cg_q.dcnt + 1'b1;
        end else begin
            cg_d.pcnt = cg_q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cg_q <= '0;
        else        cg_q <= cg_d;
    end
endmodule

// File: rtl/mfsp_engine.sv
module mfsp_engine
    import mfsp_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W),
    localparam int BW = $clog2(W + CMD_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [1:0]    fmt,
    input  logic [SW-1:0] size,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          tick,
    input  logic          tx_empty,
    input  logic [W-1:0]  tx_word,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [W-1:0]  rx_word,
    output logic          busy,
    output logic          ser_clk,
    output logic          ser_sel,
    output logic          ser_mosi,
    input  logic          ser_miso
);
    typedef struct packed {
        st_e           st;
        logic [1:0]    fmt;
        logic [SW-1:0] size;
        logic          phase;
        logic [BW-1:0] left;
        logic [W-1:0]  txs;
        logic [W-1:0]  rxs;
    } eng_s;

    eng_s          e_d, e_q;
    logic [SW-1:0] sz;
    logic [W-1:0]  keep;

    assign sz   = (size < SW'(MIN_CODE)) ? SW'(MIN_CODE) : size;
    assign keep = {W{1'b1}} >> (SW'(W - 1) - e_q.size);

    always_comb begin
        e_d     = e_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        unique case (e_q.st)
            ST_IDLE: begin
                if (en && !tx_empty) begin
                    tx_pop    = 1'b1;
                    e_d.fmt   = fmt;
                    e_d.size  = sz;
                    e_d.phase = 1'b0;
                    if (fmt == FMT_MW) begin
                        e_d.txs  = {tx_word[CMD_BITS-1:0], {(W - CMD_BITS){1'b0}}};
                        e_d.left = BW'(CMD_BITS) + BW'(sz) + 1'b1;
                    end else begin
                        e_d.txs  = tx_word << (SW'(W - 1) - sz);
                        e_d.left = BW'(sz) + 1'b1;
                    end
                    e_d.st = (fmt == FMT_TI) ? ST_PRE : ST_BITS;
                end
            end
            ST_PRE: begin
                if (tick) begin
                    e_d.phase = !e_q.phase;
                    if (e_q.phase) e_d.st = ST_BITS;
                end
            end
            ST_BITS: begin
                if (tick && !e_q.phase) begin
                    e_d.phase = 1'b1;
                    e_d.rxs   = {e_q.rxs[W-2:0], ser_miso};
                end else if (tick) begin
                    e_d.phase = 1'b0;
                    e_d.txs   = e_q.txs << 1;
                    e_d.left  = e_q.left - 1'b1;
                    if (e_q.left == BW'(1)) begin
                        rx_push = 1'b1;
                        e_d.st  = ST_IDLE;
                    end
                end
            end
            default: e_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{st: ST_IDLE, default: '0};
        else        e_q <= e_d;
    end

    assign busy     = (e_q.st != ST_IDLE);
    assign rx_word  = e_q.rxs & keep;
    assign ser_mosi = (e_q.st == ST_BITS) && e_q.txs[W-1];

    always_comb begin
        if (!busy) begin
            ser_clk = (fmt == FMT_TI || fmt == FMT_MW) ? 1'b0 : cpol;
            ser_sel = (fmt != FMT_TI);
        end else begin
            ser_sel = (e_q.fmt == FMT_TI) && (e_q.st == ST_PRE);
            case (e_q.fmt)
                FMT_TI:  ser_clk = !e_q.phase;
                FMT_MW:  ser_clk = e_q.phase;
                default: ser_clk = cpol ^ (cpha ? !e_q.phase : e_q.phase);
            endcase
        end
    end
endmodule

// File: rtl/mfsp_top.sv
module mfsp_top
    import mfsp_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    parameter int PW    = 8,
    parameter int DW    = 8,
    localparam int SW   = $clog2(W),
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic [1:0]    cfg_fmt,
    input  logic [SW-1:0] cfg_size,
    input  logic [PW-1:0] cfg_pre,
    input  logic [DW-1:0] cfg_div,
    input  logic          cfg_cpol,
    input  logic          cfg_cpha,
    input  logic          tx_push,
    input  logic [W-1:0]  tx_data,
    output logic          tx_full,
    output logic          tx_empty,
    input  logic          rx_pop,
    output logic [W-1:0]  rx_data,
    output logic          rx_full,
    output logic          rx_empty,
    input  logic          ovr_clr,
    output logic          rx_ovr,
    output logic          dma_tx_req,
    output logic          dma_rx_req,
    output logic          ser_clk,
    output logic          ser_sel,
    output logic          ser_mosi,
    input  logic          ser_miso
);
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [W-1:0]  tx_word, rx_word;
    logic          tx_pop, rx_done, eng_busy, tick;
    logic          ovr_d, ovr_q;

    mfsp_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_data),
        .pop(tx_pop), .dout(tx_word), .count(tx_cnt)
    );

    mfsp_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_done), .din(rx_word),
        .pop(rx_pop), .dout(rx_data), .count(rx_cnt)
    );

    mfsp_clkgen #(.PW(PW), .DW(DW)) u_cg (
        .clk(clk), .rst_n(rst_n), .run(eng_busy),
        .pre(cfg_pre), .div(cfg_div), .tick(tick)
    );

    mfsp_engine #(.W(W), .SW(SW)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .fmt(cfg_fmt),
        .size(cfg_size), .cpol(cfg_cpol), .cpha(cfg_cpha), .tick(tick),
        .tx_empty(tx_empty), .tx_word(tx_word), .tx_pop(tx_pop),
        .rx_push(rx_done), .rx_word(rx_word), .busy(eng_busy),
        .ser_clk(ser_clk), .ser_sel(ser_sel), .ser_mosi(ser_mosi),
        .ser_miso(ser_miso)
    );

    assign tx_full    = (tx_cnt == CW'(DEPTH));
    assign tx_empty   = (tx_cnt == '0);
    assign rx_full    = (rx_cnt == CW'(DEPTH));
    assign rx_empty   = (rx_cnt == '0);
    assign dma_tx_req = (tx_cnt <= CW'(DEPTH / 2));
    assign dma_rx_req = (rx_cnt != '0);

    always_comb begin
        ovr_d = ovr_q && !ovr_clr;
        if (rx_done && rx_full) ovr_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= ovr_d;
    end

    assign rx_ovr = ovr_q;
endmodule

// File: rtl/mfsp_chk.sv
module mfsp_chk
    import mfsp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_fmt,
    input logic       tx_full,
    input logic       rx_full,
    input logic       rx_empty,
    input logic       rx_ovr,
    input logic       ovr_clr,
    input logic       dma_tx_req,
    input logic       dma_rx_req,
    input logic       ser_sel,
    input logic       ser_mosi,
    input logic       busy
);
    p_dma_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_req == !rx_empty);

    p_dma_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> !dma_tx_req);

    p_ovr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr && !ovr_clr |=> rx_ovr);

    p_ovr_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovr) |-> $past(rx_full));

    p_idle_mosi_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ser_mosi);

    p_ti_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fmt == FMT_TI) && ser_sel |-> busy && !ser_mosi);
endmodule

bind mfsp_top mfsp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .tx_full(tx_full),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_ovr(rx_ovr),
    .ovr_clr(ovr_clr), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
    .ser_sel(ser_sel), .ser_mosi(ser_mosi), .busy(eng_busy)
);

// File: tb/mfsp_top_tb.sv
module mfsp_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b1;
    logic [1:0]  cfg_fmt = 2'd0;
    logic [4:0]  cfg_size = 5'd7;
    logic [7:0]  cfg_pre = 8'd0;
    logic [7:0]  cfg_div = 8'd0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic        tx_push = 1'b0;
    logic [31:0] tx_data = '0;
    logic        rx_pop = 1'b0;
    logic        ovr_clr = 1'b0;
    logic        ser_miso = 1'b0;
    logic        tx_full, tx_empty, rx_full, rx_empty, rx_ovr;
    logic        dma_tx_req, dma_rx_req, ser_clk, ser_sel, ser_mosi;
    logic [31:0] rx_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = !clk;

    mfsp_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_fmt(cfg_fmt),
        .cfg_size(cfg_size), .cfg_pre(cfg_pre), .cfg_div(cfg_div),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .tx_push(tx_push),
        .tx_data(tx_data), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_full(rx_full),
        .rx_empty(rx_empty), .ovr_clr(ovr_clr), .rx_ovr(rx_ovr),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
        .ser_clk(ser_clk), .ser_sel(ser_sel), .ser_mosi(ser_mosi),
        .ser_miso(ser_miso)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] f, input logic [4:0] s, input logic [7:0] p,
                           input logic [7:0] d, input logic pol, input logic pha);
        @(negedge clk);
        cfg_fmt = f; cfg_size = s; cfg_pre = p; cfg_div = d;
        cfg_cpol = pol; cfg_cpha = pha;
        @(negedge clk);
    endtask

    task automatic push_word(input logic [31:0] w);
        @(negedge clk);
        tx_push = 1'b1; tx_data = w;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    // One frame against a bench slave that replays slv as an nbits stream, MSB first
    task automatic xfer(input logic [31:0] txw, input logic [63:0] slv, input int nbits,
                        output logic [63:0] cap, output logic [31:0] rxw,
                        output int period, output int sel_hi);
        logic v, prev;
        int   k, cyc, t0, guard;
        cap = '0; rxw = '0; period = 0; sel_hi = 0;
        v = (cfg_fmt == 2'd1) ? 1'b0 : (cfg_fmt == 2'd2) ? 1'b1 :
            (cfg_cpha ? cfg_cpol : !cfg_cpol);
        ser_miso = slv[nbits-1];
        push_word(txw);
        prev = ser_clk; k = 0; cyc = 0; t0 = 0; guard = 0;
        while (k < nbits && guard < 20000) begin
            @(negedge clk);
            cyc++; guard++;
            if (ser_sel) sel_hi++;
            if (ser_clk != prev && ser_clk == v && !ser_sel) begin
                cap[nbits-1-k] = ser_mosi;
                if (k == 0) t0 = cyc;
                if (k == 1) period = cyc - t0;
                k++;
                ser_miso = (k < nbits) ? slv[nbits-1-k] : 1'b0;
            end
            prev = ser_clk;
        end
        guard = 0;
        while (rx_empty && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        rxw = rx_data;
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic t_reset;
        check(tx_empty && !tx_full, "R11 tx queue empty", {tx_full, tx_empty}, 32'h1);
        check(rx_empty && !rx_full, "R11 rx queue empty", {rx_full, rx_empty}, 32'h1);
        check(!rx_ovr, "R11 overrun clear", rx_ovr, 0);
        check(ser_sel && !ser_clk && !ser_mosi, "R11 idle pins",
              {ser_sel, ser_clk, ser_mosi}, 32'h4);
        check(dma_tx_req && !dma_rx_req, "R9 reset dma", {dma_tx_req, dma_rx_req}, 32'h2);
    endtask

    task automatic t_spi;
        logic [63:0] cap; logic [31:0] rxw; int per, sh;
        set_cfg(2'd0, 5'd7, 8'd0, 8'd0, 1'b0, 1'b0);
        xfer(32'h1234_56A5, 64'h3C, 8, cap, rxw, per, sh);
        check(cap[7:0] == 8'hA5, "R1 spi mode0 mosi", cap[31:0], 32'hA5);
        check(rxw == 32'h3C, "R1 spi mode0 rx", rxw, 32'h3C);
        set_cfg(2'd0, 5'd15, 8'd1, 8'd2, 1'b1, 1'b1);
        check(ser_clk == 1'b1, "R4 idle clock at cpol=1", ser_clk, 1);
        xfer(32'h0000_BEEF, 64'h1234, 16, cap, rxw, per, sh);
        check(cap[15:0] == 16'hBEEF, "R4 spi mode3 mosi", cap[31:0], 32'hBEEF);
        check(rxw == 32'h1234, "R4 spi mode3 rx", rxw, 32'h1234);
        check(per == 12, "R3 bit period (pre+1)(div+1)*2", per, 12);
        set_cfg(2'd0, 5'd7, 8'd0, 8'd1, 1'b0, 1'b1);
        xfer(32'h0000_0096, 64'hC3, 8, cap, rxw, per, sh);
        check(cap[7:0] == 8'h96 && rxw == 32'hC3, "R4 spi mode1", rxw, 32'hC3);
        check(per == 4, "R3 divider only", per, 4);
        check(sh == 0, "R1 select low during frame", sh, 0);
    endtask

    task automatic t_sizes;
        logic [63:0] cap; logic [31:0] rxw; int per, sh;
        set_cfg(2'd0, 5'd31, 8'd0, 8'd0, 1'b0, 1'b0);
        xfer(32'hDEAD_BEEF, 64'h89AB_CDEF, 32, cap, rxw, per, sh);
        check(cap[31:0] == 32'hDEAD_BEEF, "R2 32-bit mosi", cap[31:0], 32'hDEADBEEF);
        check(rxw == 32'h89AB_CDEF, "R2 32-bit rx", rxw, 32'h89ABCDEF);
        set_cfg(2'd0, 5'd3, 8'd0, 8'd0, 1'b0, 1'b0);
        xfer(32'hFFFF_FFF6, 64'h9, 4, cap, rxw, per, sh);
        check(cap[31:0] == 32'h6, "R2 4-bit low bits only", cap[31:0], 32'h6);
        check(rxw == 32'h9, "R2 4-bit rx zero-extended", rxw, 32'h9);
        set_cfg(2'd0, 5'd1, 8'd0, 8'd0, 1'b0, 1'b0);
        xfer(32'h0000_000A, 64'h5, 4, cap, rxw, per, sh);
        check(cap[31:0] == 32'hA && rxw == 32'h5, "R2 short code clamps to 4", rxw, 32'h5);
    endtask

    task automatic t_ti;
        logic [63:0] cap; logic [31:0] rxw; int per, sh;
        set_cfg(2'd1, 5'd11, 8'd0, 8'd1, 1'b0, 1'b0);
        check(!ser_sel && !ser_clk, "R5 ti idle low", {ser_sel, ser_clk}, 0);
        xfer(32'hF00F_FABC, 64'h5A3, 12, cap, rxw, per, sh);
        check(cap[31:0] == 32'hABC, "R5 ti mosi", cap[31:0], 32'hABC);
        check(rxw == 32'h5A3, "R5 ti rx", rxw, 32'h5A3);
        check(sh == 4, "R5 frame pulse one bit wide", sh, 4);
    endtask

    task automatic t_mw;
        logic [63:0] cap; logic [31:0] rxw; int per, sh;
        set_cfg(2'd2, 5'd7, 8'd0, 8'd0, 1'b0, 1'b0);
        xfer(32'h0000_03C2, 64'h7E, 16, cap, rxw, per, sh);
        check(cap[15:8] == 8'hC2, "R6 command byte", cap[15:8], 32'hC2);
        check(cap[7:0] == 8'h00, "R6 mosi low during reply", cap[7:0], 0);
        check(rxw == 32'h7E, "R6 reply word", rxw, 32'h7E);
        check(sh == 0, "R6 select held low", sh, 0);
    endtask

    task automatic t_queues;
        int guard;
        logic all_zero;
        set_cfg(2'd0, 5'd3, 8'd0, 8'd0, 1'b0, 1'b0);
        cfg_en = 1'b0;
        ser_miso = 1'b0;
        for (int i = 0; i < 16; i++) push_word(32'(i));
        check(dma_tx_req, "R9 tx request at half", dma_tx_req, 1);
        push_word(32'd16);
        check(!dma_tx_req, "R9 tx request drops above half", dma_tx_req, 0);
        for (int i = 17; i < 32; i++) push_word(32'(i));
        check(tx_full, "R7 tx full at 32", tx_full, 1);
        push_word(32'hFF);
        check(ser_sel && !tx_empty, "R12 no frame while disabled", {ser_sel, tx_empty}, 32'h2);
        @(negedge clk);
        cfg_en = 1'b1;
        guard = 0;
        while (!(tx_empty && ser_sel) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (20) @(negedge clk);
        check(rx_full, "R8 rx holds 32", rx_full, 1);
        check(!rx_ovr, "R7 push on full dropped", rx_ovr, 0);
        check(dma_rx_req, "R9 rx request", dma_rx_req, 1);
        ser_miso = 1'b1;
        push_word(32'h5);
        repeat (40) @(negedge clk);
        check(rx_ovr, "R10 overrun set", rx_ovr, 1);
        ser_miso = 1'b0;
        all_zero = 1'b1;
        for (int i = 0; i < 32; i++) begin
            if (rx_data != 32'h0) all_zero = 1'b0;
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
        end
        check(all_zero, "R10 overrun frame discarded", all_zero, 1);
        check(rx_empty && !dma_rx_req, "R9 rx request drops when empty",
              {rx_empty, dma_rx_req}, 32'h2);
        check(rx_ovr, "R10 flag sticky", rx_ovr, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        check(!rx_ovr, "R10 flag cleared", rx_ovr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_spi();
        t_sizes();
        t_ti();
        t_mw();
        t_queues();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule